// File: doc/BRIEF.md
# Field Completion Tracker

This block follows the completion of field writes into memory and tells software about them. The write engine gives it a one-cycle pulse for each finished line, with that line's number. It also gives a one-cycle pulse for each finished field, with the field's start address, width, height, F1 flag and a broken indication. Software reaches the block through a small register port. The write strobe, address and write data act in the clock edge that samples them. The read data is a combinational function of the register address.

A finished field normally sets a buffer-available flag and latches the field's description. While the flag is set, that description stays frozen, so software can read a consistent snapshot. Writing any value to the acknowledge register clears the flag. A count of written buffers runs until software writes the commit register.

Software can choose to hide damaged fields. When hiding is on, a field that is flagged broken, or whose height is not the programmed expected height, leaves the flag, the snapshot and the count untouched. Two sticky status bits record field and line events. Each has its own enable, and a registered interrupt line combines the enabled bits.

Top module: `field_done_tracker`

## Requirements
- R1: After synchronous reset every register read returns 0 and `irq` is 0.
- R2: An accepted field pulse sets the available flag (address 7, bit 0) and latches the start address (address 9), width (address 10), height (address 11) and F1 flag (address 12, bit 0) when the flag was clear.
- R3: While the available flag is set and no acknowledge is written, further accepted fields do not change addresses 9 to 12.
- R4: Writing any value to address 6 clears the available flag. If an accepted field arrives in the same cycle, the flag stays set and the new field's data is latched.
- R5: The write count (address 8) rises by one for each accepted field. Writing any value to address 5 resets it to 0, or to 1 if an accepted field arrives in that same cycle.
- R6: When bit 0 of address 3 is set, a field with the broken input high, or with a height different from the expected height (address 4, bits 16:0), is not accepted. With the bit clear, every field pulse is accepted.
- R7: Status bit 1 (address 1) sets when a line pulse carries a line number equal to the threshold (address 2, bits 16:0). Line numbering starts at 0.
- R8: Status bit 0 sets on every field pulse, whether or not the field is accepted.
- R9: Writing address 1 clears each status bit whose write-data bit is 1. A new event in the same cycle keeps its bit set.
- R10: `irq` in each cycle equals the OR over both bits of status AND enable (address 0: bit 0 field, bit 1 line) as they stood one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| line_done | input | 1 | One-cycle pulse: a line finished writing |
| line_num | input | 17 | Number of the finished line |
| field_done | input | 1 | One-cycle pulse: a field finished writing |
| fld_start | input | 32 | Start address of the finished field |
| fld_width | input | 17 | Width of the finished field |
| fld_height | input | 17 | Height of the finished field |
| fld_f1 | input | 1 | F1 flag of the finished field |
| fld_broken | input | 1 | Finished field is damaged |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that the field and line pulses are independent single-cycle strobes whose data is valid only while the strobe is high. They also assume that a register write names exactly one address per cycle. The stimulus obeys this: it drives pulses and writes for one cycle at a time and changes field data only together with the pulse. It still lets acknowledges, commits, status clears and events fall into the same cycle, because those collisions are the cases the priority rules decide.

// File: rtl/fdt_pkg.sv
package fdt_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 32;
    localparam int DIM_W  = 17;
    localparam int LINE_W = 17;
    localparam int CNT_W  = 32;
    localparam int RA_W   = 4;
    localparam int IRQ_N  = 2;
    localparam int IRQ_FIELD = 0;
    localparam int IRQ_LINE  = 1;

    typedef enum logic [RA_W-1:0] {
        RA_IRQ_EN   = 4'd0,
        RA_IRQ_STAT = 4'd1,
        RA_LINE_THR = 4'd2,
        RA_HIDE_BAD = 4'd3,
        RA_EXP_H    = 4'd4,
        RA_COMMIT   = 4'd5,
        RA_ACK      = 4'd6,
        RA_AVAIL    = 4'd7,
        RA_WCOUNT   = 4'd8,
        RA_START    = 4'd9,
        RA_WIDTH    = 4'd10,
        RA_HEIGHT   = 4'd11,
        RA_F1       = 4'd12
    } reg_addr_e;

    typedef struct packed {
        logic [ADDR_W-1:0] start;
        logic [DIM_W-1:0]  width;
        logic [DIM_W-1:0]  height;
        logic              f1;
    } buf_info_t;

    function automatic logic [DATA_W-1:0] zext_dim(input logic [DIM_W-1:0] v);
        return {{(DATA_W-DIM_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/fdt_cfg.sv
module fdt_cfg
    import fdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [RA_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [IRQ_N-1:0]  irq_en,
    output logic [LINE_W-1:0] line_thr,
    output logic              hide_bad,
    output logic [DIM_W-1:0]  exp_h,
    output logic              commit_p,
    output logic              ack_p,
    output logic [IRQ_N-1:0]  stat_clr
);

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wr_data[DATA_W-1:DIM_W];

    assign commit_p = wr_en && (wr_addr == RA_COMMIT);
    assign ack_p    = wr_en && (wr_addr == RA_ACK);
    assign stat_clr = (wr_en && (wr_addr == RA_IRQ_STAT)) ? wr_data[IRQ_N-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_en   <= '0;
            line_thr <= '0;
            hide_bad <= 1'b0;
            exp_h    <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                RA_IRQ_EN:   irq_en   <= wr_data[IRQ_N-1:0];
                RA_LINE_THR: line_thr <= wr_data[LINE_W-1:0];
                RA_HIDE_BAD: hide_bad <= wr_data[0];
                RA_EXP_H:    exp_h    <= wr_data[DIM_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fdt_bufinfo.sv
module fdt_bufinfo
    import fdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             field_done,
    input  buf_info_t        info_in,
    input  logic             broken,
    input  logic             hide_bad,
    input  logic [DIM_W-1:0] exp_h,
    input  logic             ack_p,
    input  logic             commit_p,
    output logic             avail,
    output buf_info_t        info,
    output logic [CNT_W-1:0] wcount
);

    logic damaged;
    logic accept;
    logic capture;

    assign damaged = broken || (info_in.height != exp_h);
    assign accept  = field_done && !(hide_bad && damaged);
    assign capture = accept && (!avail || ack_p);

    always_ff @(posedge clk) begin
        if (rst) begin
            avail <= 1'b0;
        end else if (accept) begin
            avail <= 1'b1;
        end else if (ack_p) begin
            avail <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            info <= '0;
        end else if (capture) begin
            info <= info_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wcount <= '0;
        end else if (commit_p) begin
            wcount <= {{(CNT_W-1){1'b0}}, accept};
        end else if (accept) begin
            wcount <= wcount + 1'b1;
        end
    end

endmodule

// File: rtl/fdt_irq.sv
module fdt_irq
    import fdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              field_done,
    input  logic              line_done,
    input  logic [LINE_W-1:0] line_num,
    input  logic [LINE_W-1:0] line_thr,
    input  logic [IRQ_N-1:0]  irq_en,
    input  logic [IRQ_N-1:0]  stat_clr,
    output logic [IRQ_N-1:0]  stat,
    output logic              irq
);

    logic [IRQ_N-1:0] ev;
    logic [IRQ_N-1:0] stat_d;

    always_comb begin
        ev            = '0;
        ev[IRQ_FIELD] = field_done;
        ev[IRQ_LINE]  = line_done && (line_num == line_thr);
        for (int b = 0; b < IRQ_N; b++) begin
            stat_d[b] = ev[b] || (stat[b] && !stat_clr[b]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            irq  <= 1'b0;
        end else begin
            stat <= stat_d;
            irq  <= |(stat & irq_en);
        end
    end

endmodule

// File: rtl/field_done_tracker.sv
module field_done_tracker
    import fdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              line_done,
    input  logic [LINE_W-1:0] line_num,
    input  logic              field_done,
    input  logic [ADDR_W-1:0] fld_start,
    input  logic [DIM_W-1:0]  fld_width,
    input  logic [DIM_W-1:0]  fld_height,
    input  logic              fld_f1,
    input  logic              fld_broken,
    output logic              irq
);

    logic [IRQ_N-1:0]  irq_en;
    logic [LINE_W-1:0] line_thr;
    logic              hide_bad;
    logic [DIM_W-1:0]  exp_h;
    logic              commit_p;
    logic              ack_p;
    logic [IRQ_N-1:0]  stat_clr;
    logic [IRQ_N-1:0]  stat;
    logic              avail;
    buf_info_t         info;
    buf_info_t         info_in;
    logic [CNT_W-1:0]  wcount;

    assign info_in = '{start: fld_start, width: fld_width, height: fld_height, f1: fld_f1};

    fdt_cfg u_cfg (
        .clk(clk), .rst(rst),
        .wr_en(reg_wr), .wr_addr(reg_addr), .wr_data(reg_wdata),
        .irq_en(irq_en), .line_thr(line_thr), .hide_bad(hide_bad), .exp_h(exp_h),
        .commit_p(commit_p), .ack_p(ack_p), .stat_clr(stat_clr)
    );

    fdt_bufinfo u_buf (
        .clk(clk), .rst(rst),
        .field_done(field_done), .info_in(info_in), .broken(fld_broken),
        .hide_bad(hide_bad), .exp_h(exp_h), .ack_p(ack_p), .commit_p(commit_p),
        .avail(avail), .info(info), .wcount(wcount)
    );

    fdt_irq u_irq (
        .clk(clk), .rst(rst),
        .field_done(field_done), .line_done(line_done), .line_num(line_num),
        .line_thr(line_thr), .irq_en(irq_en), .stat_clr(stat_clr),
        .stat(stat), .irq(irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_IRQ_EN:   reg_rdata[IRQ_N-1:0]  = irq_en;
            RA_IRQ_STAT: reg_rdata[IRQ_N-1:0]  = stat;
            RA_LINE_THR: reg_rdata[LINE_W-1:0] = line_thr;
            RA_HIDE_BAD: reg_rdata[0]          = hide_bad;
            RA_EXP_H:    reg_rdata             = zext_dim(exp_h);
            RA_AVAIL:    reg_rdata[0]          = avail;
            RA_WCOUNT:   reg_rdata[CNT_W-1:0]  = wcount;
            RA_START:    reg_rdata[ADDR_W-1:0] = info.start;
            RA_WIDTH:    reg_rdata             = zext_dim(info.width);
            RA_HEIGHT:   reg_rdata             = zext_dim(info.height);
            RA_F1:       reg_rdata[0]          = info.f1;
            default:     reg_rdata             = '0;
        endcase
    end

endmodule

// File: rtl/fdt_checker.sv
module fdt_checker
    import fdt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [RA_W-1:0]   reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              line_done,
    input logic [LINE_W-1:0] line_num,
    input logic              field_done,
    input logic              irq,
    input logic [IRQ_N-1:0]  irq_en,
    input logic [IRQ_N-1:0]  stat,
    input logic [LINE_W-1:0] line_thr,
    input logic              hide_bad,
    input logic              avail,
    input buf_info_t         info,
    input logic [CNT_W-1:0]  wcount
);

    logic wr_ack, wr_commit, wr_stat;
    assign wr_ack    = reg_wr && (reg_addr == RA_ACK);
    assign wr_commit = reg_wr && (reg_addr == RA_COMMIT);
    assign wr_stat   = reg_wr && (reg_addr == RA_IRQ_STAT);

    AST_FIELD_SETS_AVAIL: assert property (@(posedge clk) disable iff (rst)
        field_done && !hide_bad |=> avail);                                   // R2
    AST_INFO_FROZEN: assert property (@(posedge clk) disable iff (rst)
        avail && !wr_ack |=> $stable(info));                                  // R3
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        wr_ack && !field_done |=> !avail);                                    // R4
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !wr_commit |=> (wcount == $past(wcount)) || (wcount == $past(wcount) + 1)); // R5
    AST_LINE_HIT: assert property (@(posedge clk) disable iff (rst)
        line_done && (line_num == line_thr) |=> stat[IRQ_LINE]);              // R7
    AST_W1C_FIELD: assert property (@(posedge clk) disable iff (rst)
        wr_stat && reg_wdata[IRQ_FIELD] && !field_done |=> !stat[IRQ_FIELD]); // R9
    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq == $past(|(stat & irq_en)));                             // R10

endmodule

bind field_done_tracker fdt_checker u_fdt_checker (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .line_done(line_done), .line_num(line_num), .field_done(field_done), .irq(irq),
    .irq_en(irq_en), .stat(stat), .line_thr(line_thr), .hide_bad(hide_bad),
    .avail(avail), .info(info), .wcount(wcount)
);

// File: tb/field_done_tracker_bench.sv
module field_done_tracker_bench;
    import fdt_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr = 1'b0;
    logic [RA_W-1:0]   reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              line_done = 1'b0;
    logic [LINE_W-1:0] line_num = '0;
    logic              field_done = 1'b0;
    logic [ADDR_W-1:0] fld_start = '0;
    logic [DIM_W-1:0]  fld_width = '0;
    logic [DIM_W-1:0]  fld_height = '0;
    logic              fld_f1 = 1'b0;
    logic              fld_broken = 1'b0;
    logic              irq;

    always #10 clk = ~clk;

    field_done_tracker u_field_done_tracker (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .line_done(line_done), .line_num(line_num),
        .field_done(field_done), .fld_start(fld_start), .fld_width(fld_width),
        .fld_height(fld_height), .fld_f1(fld_f1), .fld_broken(fld_broken), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference state
    int unsigned m_en, m_stat, m_thr, m_hide, m_exph, m_avail, m_cnt;
    int unsigned m_start, m_w, m_h, m_f1, m_irq;

    always @(posedge clk) begin
        int unsigned a, acc, cap, ack, nirq, setv, clr;
        if (rst) begin
            m_en = 0; m_stat = 0; m_thr = 0; m_hide = 0; m_exph = 0; m_avail = 0;
            m_cnt = 0; m_start = 0; m_w = 0; m_h = 0; m_f1 = 0; m_irq = 0;
        end else begin
            a    = reg_wr ? int'(reg_addr) : 99;
            ack  = (a == 6) ? 1 : 0;
            acc  = (field_done && !(m_hide != 0 && (fld_broken || int'(fld_height) != m_exph))) ? 1 : 0;
            cap  = (acc != 0 && (m_avail == 0 || ack != 0)) ? 1 : 0;
            nirq = ((m_stat & m_en) != 0) ? 1 : 0;
            setv = (field_done ? 1 : 0) + ((line_done && int'(line_num) == m_thr) ? 2 : 0);
            clr  = (a == 1) ? (reg_wdata & 3) : 0;
            m_stat = (m_stat & ~clr & 3) | setv;
            if (acc != 0) m_avail = 1; else if (ack != 0) m_avail = 0;
            if (a == 5) m_cnt = acc; else m_cnt = m_cnt + acc;
            if (cap != 0) begin
                m_start = fld_start; m_w = fld_width; m_h = fld_height; m_f1 = fld_f1;
            end
            if (a == 0) m_en = reg_wdata & 3;
            if (a == 2) m_thr = reg_wdata & 32'h1FFFF;
            if (a == 3) m_hide = reg_wdata & 1;
            if (a == 4) m_exph = reg_wdata & 32'h1FFFF;
            m_irq = nirq;
        end
    end

    function automatic int unsigned exp_rd(input int unsigned a);
        case (a)
            0: return m_en;      1: return m_stat;   2: return m_thr;
            3: return m_hide;    4: return m_exph;   7: return m_avail;
            8: return m_cnt;     9: return m_start;  10: return m_w;
            11: return m_h;      12: return m_f1;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(input int unsigned a);
        case (a)
            0: return "R10"; 1: return "R9"; 2: return "R7"; 3, 4: return "R6";
            5, 6, 7: return "R4"; 8: return "R5";
            default: return "R3";
        endcase
    endfunction

    task automatic check(input string tag, input int unsigned act, input int unsigned exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R10", irq, m_irq);
        check(tag_of(reg_addr), reg_rdata, exp_rd(reg_addr));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        reg_wr = 0; field_done = 0; line_done = 0; fld_broken = 0;
    endtask

    task automatic wr(input int unsigned a, input int unsigned d);
        reg_wr = 1; reg_addr = a[RA_W-1:0]; reg_wdata = d;
        tick();
    endtask

    task automatic set_fld(input int unsigned s, input int unsigned w, input int unsigned h,
                           input bit f1, input bit br);
        field_done = 1; fld_start = s; fld_width = w[DIM_W-1:0];
        fld_height = h[DIM_W-1:0]; fld_f1 = f1; fld_broken = br;
    endtask

    task automatic rd(input int unsigned a, input string tag, input int unsigned exp);
        reg_wr = 0; reg_addr = a[RA_W-1:0];
        #1;
        check(tag, reg_rdata, exp);
    endtask

    initial begin
        #3_000_000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        for (int a = 0; a < 16; a++) rd(a, "R1", 0);
        check("R1", irq, 0);

        wr(0, 3); wr(2, 5);
        for (int n = 0; n < 8; n++) begin
            line_done = 1; line_num = n[LINE_W-1:0];
            tick();
            if (n == 4) rd(1, "R7", 0);
            if (n == 5) rd(1, "R7", 2);
            if (n == 6) check("R10", irq, 1);
        end
        wr(1, 2); rd(1, "R9", 0);

        set_fld(32'h1000, 640, 480, 1, 0); tick();
        rd(7, "R2", 1); rd(9, "R2", 32'h1000); rd(10, "R2", 640);
        rd(11, "R2", 480); rd(12, "R2", 1); rd(1, "R8", 1); rd(8, "R5", 1);
        set_fld(32'h2000, 320, 240, 0, 0); tick();
        rd(9, "R3", 32'h1000); rd(11, "R3", 480); rd(8, "R5", 2);
        wr(6, 32'hDEAD); rd(7, "R4", 0); rd(9, "R3", 32'h1000);
        set_fld(32'h3000, 100, 50, 0, 0); tick();
        rd(9, "R2", 32'h3000);
        reg_wr = 1; reg_addr = 6; set_fld(32'h4000, 200, 60, 1, 0); tick();
        rd(7, "R4", 1); rd(9, "R4", 32'h4000); rd(12, "R4", 1);
        wr(5, 7); rd(8, "R5", 0);
        reg_wr = 1; reg_addr = 5; set_fld(32'h4400, 200, 60, 0, 0); tick();
        rd(8, "R5", 1);
        wr(6, 0); wr(4, 480); wr(3, 1); wr(1, 3);
        set_fld(32'h5000, 640, 480, 0, 1); tick();
        rd(7, "R6", 0); rd(8, "R6", 1); rd(9, "R6", 32'h4000); rd(1, "R8", 1);
        set_fld(32'h6000, 640, 479, 0, 0); tick();
        rd(7, "R6", 0); rd(8, "R6", 1);
        set_fld(32'h7000, 640, 480, 0, 0); tick();
        rd(7, "R6", 1); rd(8, "R6", 2); rd(9, "R6", 32'h7000);
        reg_wr = 1; reg_addr = 1; reg_wdata = 1; set_fld(32'h7100, 640, 480, 0, 0); tick();
        rd(1, "R9", 1);
        wr(0, 0); tick(); check("R10", irq, 0);

        wr(4, 8); wr(2, 3);
        for (int i = 0; i < 6000; i++) begin
            int unsigned r;
            r = $urandom_range(0, 99);
            if (r < 12) begin
                reg_wr = 1;
                reg_addr = RA_W'($urandom_range(0, 6));
                reg_wdata = $urandom;
                if (reg_addr == 2 || reg_addr == 4) reg_wdata = $urandom_range(0, 9);
            end else begin
                reg_addr = RA_W'($urandom_range(0, 15));
            end
            if ($urandom_range(0, 9) < 3) begin
                line_done = 1; line_num = LINE_W'($urandom_range(0, 9));
            end
            if ($urandom_range(0, 9) < 2)
                set_fld($urandom, $urandom_range(0, 2000), $urandom_range(6, 10),
                        1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0));
            tick();
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule